// File: doc/BRIEF.md
# Time-Multiplexed Binary Sorter

This block orders N records by a one-bit key. Each record carries a payload that travels with its key. A start pulse captures all N records in one cycle. The records are split into K equal groups. One small binary sorter, G = N/K records wide, is shared across the groups: on each of K clock steps an input multiplexer presents one group to it, and the sorted group is written into its own slot of a run buffer.

When all K slots are filled, a combinational K-way merger turns the K sorted runs into one sorted sequence. It works level by level. At each level it looks at the centre key of every run. The half of each run that must be uniform is split off, and the uniform halves are placed in order by their leading bit, zeros first and then ones. The remaining halves go on to the next level. When the runs are one record long, a K-input sorter orders what is left. Two-way mergers then combine the pieces on the way back up. The merged result is registered, `done` pulses, and the block returns to idle.

Output index 0 holds the smallest key. Ascending order therefore means that every key-0 record sits at a lower index than every key-1 record.

Top module: `bsort_tm_top`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `out_key` and `out_pay` are all zero.
- R2: A `start` seen while idle is accepted. `busy` is 1 in the next cycle. `done` is 1 for exactly one cycle, K+1 cycles after the accepting edge, and `busy` is 0 in that cycle.
- R3: A `start` that arrives while `busy` is 1 is ignored. It changes neither the result nor the `done` latency of the sort in progress.
- R4: Keys and payloads are sampled only at the accepting edge. Changes on `in_key` or `in_pay` while busy do not alter the result.
- R5: When `done` is 1, `out_key` holds as many ones as the captured keys. Every 0 sits at a lower index than every 1: bits 0 up to z-1 are 0, where z is the number of zero keys.
- R6: Record i uses key bit `in_key[i]` and payload bits `in_pay[8*i+7 : 8*i]`, and the outputs use the same layout. The set of (key, payload) pairs at the output equals the set that was captured.
- R7: `out_key` and `out_pay` keep their values from one `done` pulse to the next, whatever the inputs do.
- R8: A new `start` may be accepted in the same cycle that `done` is 1. The following sort then behaves as in R2, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to capture the inputs and begin a sort |
| in_key | input | N | One key bit per record |
| in_pay | input | N*8 | Payload of each record, 8 bits per record |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | One-cycle pulse: the outputs hold a new result |
| out_key | output | N | Sorted keys, zeros at low indices |
| out_pay | output | N*8 | Payloads in the same order as `out_key` |

## Verification
The bench builds the block with N = 16 and K = 4, so each group is 4 records wide. With these values the merger runs two splitting levels, with run lengths going 4 to 2 to 1, then the final 4-input sort, then two two-way merges. Every stage of the merge sits on the path of every vector. Tabled patterns such as all-zero, all-one, a single set bit and alternating bits drive the centre-key selects to both values in mixed combinations. Random keys with distinct payloads expose any record that is lost or duplicated.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    localparam int unsigned PAY_W = 8;

    typedef struct packed {
        logic             key;
        logic [PAY_W-1:0] pay;
    } item_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_MERGE = 2'd2
    } phase_t;

endpackage

// File: rtl/bsort_group_sort.sv
module bsort_group_sort
    import bsort_pkg::*;
#(
    parameter int M = 4
) (
    input  item_t [M-1:0] din,
    output item_t [M-1:0] dout
);

    // Rank placement: each record goes to its slot among the zeros or among the ones.
    always_comb begin
        int zeros;
        int z_seen;
        int o_seen;
        zeros  = 0;
        z_seen = 0;
        o_seen = 0;
        dout   = '0;
        for (int i = 0; i < M; i++) begin
            if (!din[i].key) zeros++;
        end
        for (int i = 0; i < M; i++) begin
            if (!din[i].key) begin
                dout[z_seen] = din[i];
                z_seen++;
            end else begin
                dout[zeros + o_seen] = din[i];
                o_seen++;
            end
        end
    end

endmodule

// File: rtl/bsort_kway_merge.sv
module bsort_kway_merge
    import bsort_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 4
) (
    input  item_t [N-1:0] din,
    output item_t [N-1:0] dout
);

    localparam int G  = N / K;
    localparam int LV = $clog2(G);

    item_t rest [N];
    item_t nxt  [N];
    item_t tmp  [N];
    item_t acc  [N];
    item_t uni  [LV][N];

    always_comb begin
        int  len;
        int  half;
        int  nz;
        int  zi;
        int  oi;
        int  slot;
        int  h;
        int  za;
        int  zb;
        logic mid;
        len  = 0;
        half = 0;
        nz   = 0;
        zi   = 0;
        oi   = 0;
        slot = 0;
        h    = 0;
        za   = 0;
        zb   = 0;
        mid  = 1'b0;
        for (int i = 0; i < N; i++) begin
            rest[i] = din[i];
            nxt[i]  = '0;
            tmp[i]  = '0;
            acc[i]  = '0;
        end
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < N; i++) uni[l][i] = '0;
        end

        // Split levels: the centre key of each run picks its uniform half.
        for (int l = 0; l < LV; l++) begin
            len  = G >> l;
            half = len / 2;
            nz   = 0;
            for (int r = 0; r < K; r++) begin
                if (!rest[r*len + half].key) nz++;
            end
            zi = 0;
            oi = 0;
            for (int r = 0; r < K; r++) begin
                mid = rest[r*len + half].key;
                if (mid) begin
                    slot = nz + oi;
                    oi++;
                end else begin
                    slot = zi;
                    zi++;
                end
                for (int e = 0; e < half; e++) begin
                    uni[l][slot*half + e] = mid ? rest[r*len + half + e] : rest[r*len + e];
                    nxt[r*half + e]       = mid ? rest[r*len + e] : rest[r*len + half + e];
                end
            end
            for (int i = 0; i < N; i++) rest[i] = nxt[i];
        end

        // K single-record runs remain: a K-input binary sort.
        nz = 0;
        for (int r = 0; r < K; r++) begin
            if (!rest[r].key) nz++;
        end
        zi = 0;
        oi = 0;
        for (int r = 0; r < K; r++) begin
            if (!rest[r].key) begin
                acc[zi] = rest[r];
                zi++;
            end else begin
                acc[nz + oi] = rest[r];
                oi++;
            end
        end

        // Two-way merges of equal sorted halves, deepest level first.
        for (int l = LV - 1; l >= 0; l--) begin
            h  = K * (G >> (l + 1));
            za = 0;
            zb = 0;
            for (int p = 0; p < h; p++) begin
                if (!uni[l][p].key) za++;
                if (!acc[p].key) zb++;
            end
            for (int p = 0; p < 2*h; p++) begin
                if (p < za)           tmp[p] = uni[l][p];
                else if (p < za + zb) tmp[p] = acc[p - za];
                else if (p < h + zb)  tmp[p] = uni[l][p - zb];
                else                  tmp[p] = acc[p - h];
            end
            for (int i = 0; i < N; i++) acc[i] = tmp[i];
        end

        for (int i = 0; i < N; i++) dout[i] = acc[i];
    end

endmodule

// File: rtl/bsort_tm_top.sv
module bsort_tm_top
    import bsort_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [N-1:0]       in_key,
    input  logic [N*PAY_W-1:0] in_pay,
    output logic               busy,
    output logic               done,
    output logic [N-1:0]       out_key,
    output logic [N*PAY_W-1:0] out_pay
);

    localparam int G  = N / K;
    localparam int SW = $clog2(K);

    phase_t          ph_q;
    logic [SW-1:0]   step_q;
    logic            done_q;
    item_t [N-1:0]   in_items;
    item_t [N-1:0]   cap_q;
    item_t [N-1:0]   out_q;
    item_t [G-1:0]   grp_in;
    item_t [G-1:0]   grp_srt;
    item_t [G-1:0]   slot_q [K];
    item_t [N-1:0]   run_buf;
    item_t [N-1:0]   merged;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_items[i].key = in_key[i];
            in_items[i].pay = in_pay[i*PAY_W +: PAY_W];
        end
    end

    // Input multiplexer: the current group goes to the shared sorter.
    always_comb begin
        for (int g = 0; g < G; g++) grp_in[g] = cap_q[int'(step_q)*G + g];
    end

    bsort_group_sort #(.M(G)) u_grp_sort (
        .din  (grp_in),
        .dout (grp_srt)
    );

    // Demultiplexer: one run slot per group index.
    for (genvar j = 0; j < K; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[j] <= '0;
            end else if (ph_q == ST_LOAD && step_q == SW'(j)) begin
                slot_q[j] <= grp_srt;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < K; j++) begin
            for (int g = 0; g < G; g++) run_buf[j*G + g] = slot_q[j][g];
        end
    end

    bsort_kway_merge #(.N(N), .K(K)) u_merge (
        .din  (run_buf),
        .dout (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= ST_IDLE;
            step_q <= '0;
            done_q <= 1'b0;
            cap_q  <= '0;
            out_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                ST_IDLE: begin
                    if (start) begin
                        cap_q  <= in_items;
                        step_q <= '0;
                        ph_q   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (step_q == SW'(K - 1)) ph_q <= ST_MERGE;
                    step_q <= step_q + SW'(1);
                end
                ST_MERGE: begin
                    out_q  <= merged;
                    done_q <= 1'b1;
                    ph_q   <= ST_IDLE;
                end
                default: ph_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (ph_q != ST_IDLE);
    assign done = done_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            out_key[i]                 = out_q[i].key;
            out_pay[i*PAY_W +: PAY_W]  = out_q[i].pay;
        end
    end

endmodule

// File: rtl/bsort_tm_chk.sv
module bsort_tm_chk #(
    parameter int N = 16,
    parameter int K = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] in_key,
    input logic [N-1:0] out_key
);

    // cnt_q is 1 after the accepting edge, so K+1 cycles later it reads K+2.
    int unsigned  cnt_q;
    logic [N-1:0] cap_key_q;
    logic [N-1:0] inv_key;
    logic         low_mask_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= 0;
            cap_key_q <= '0;
        end else if (start && !busy) begin
            cnt_q     <= 1;
            cap_key_q <= in_key;
        end else if (done) begin
            cnt_q <= 0;
        end else if (cnt_q != 0) begin
            cnt_q <= cnt_q + 1;
        end
    end

    assign inv_key     = ~out_key;
    assign low_mask_ok = ((inv_key & (inv_key + N'(1))) == '0);

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_q == K + 2));

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> low_mask_ok);

    p_ones_kept_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(out_key) == $countones(cap_key_q)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(out_key));

endmodule

bind bsort_tm_top bsort_tm_chk #(.N(N), .K(K)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .in_key  (in_key),
    .out_key (out_key)
);

// File: tb/tb_bsort_tm_top.sv
module tb_bsort_tm_top;
    import bsort_pkg::*;

    localparam int N   = 16;
    localparam int K   = 4;
    localparam int LAT = K + 1;
    localparam int NV  = 14;

    typedef struct packed {
        logic [N-1:0] key;
        logic [N-1:0] exp_key;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h0000},
        '{16'hFFFF, 16'hFFFF},
        '{16'h0001, 16'h8000},
        '{16'h8000, 16'h8000},
        '{16'hAAAA, 16'hFF00},
        '{16'h5555, 16'hFF00},
        '{16'h1234, 16'hF800},
        '{16'hF0F0, 16'hFF00},
        '{16'h0F0F, 16'hFF00},
        '{16'h7FFF, 16'hFFFE},
        '{16'hFFFE, 16'hFFFE},
        '{16'h3C5A, 16'hFF00},
        '{16'h00FF, 16'hFF00},
        '{16'h0110, 16'hC000}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [N-1:0]       in_key = '0;
    logic [N*PAY_W-1:0] in_pay = '0;
    logic               busy;
    logic               done;
    logic [N-1:0]       out_key;
    logic [N*PAY_W-1:0] out_pay;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    bsort_tm_top #(.N(N), .K(K)) dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .in_key  (in_key),
        .in_pay  (in_pay),
        .busy    (busy),
        .done    (done),
        .out_key (out_key),
        .out_pay (out_pay)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N*PAY_W-1:0] make_pay(input int seed);
        logic [N*PAY_W-1:0] p;
        for (int i = 0; i < N; i++) p[i*PAY_W +: PAY_W] = PAY_W'(i*37 + seed*11);
        return p;
    endfunction

    // Start a sort at the current negedge and wait for done. With poke set,
    // start is raised again and the inputs are inverted while busy.
    task automatic run_sort(input logic [N-1:0] key, input int seed,
                            input logic [N-1:0] exp_key, input string req,
                            input bit poke);
        logic [N*PAY_W-1:0] pay;
        logic [N-1:0]       used;
        bit                 all_found;
        bit                 found;
        int                 lat;
        pay    = make_pay(seed);
        in_key = key;
        in_pay = pay;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R2", "busy after start", {busy, done}, 2'b10);
        lat = 0;
        while (done !== 1'b1 && lat < 40) begin
            if (poke && lat == 0) begin
                start  = 1'b1;
                in_key = ~key;
                in_pay = ~pay;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == LAT, poke ? "R3" : "R2", "done latency", lat, LAT);
        check(busy === 1'b0, "R2", "busy low with done", busy, 1'b0);
        check(out_key === exp_key, poke ? "R4" : req, "sorted keys", out_key, exp_key);
        used      = '0;
        all_found = 1'b1;
        for (int j = 0; j < N; j++) begin
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (!found && !used[i] && key[i] === out_key[j] &&
                    pay[i*PAY_W +: PAY_W] === out_pay[j*PAY_W +: PAY_W]) begin
                    used[i] = 1'b1;
                    found   = 1'b1;
                end
            end
            if (!found) all_found = 1'b0;
        end
        check(all_found, "R6", "payload set", used, {N{1'b1}});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0]       hk;
        logic [N*PAY_W-1:0] hp;
        logic [N-1:0]       rk;
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        check(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {busy, done}, 2'b00);
        check(out_key === '0 && out_pay === '0, "R1", "outputs in reset", out_key, '0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && out_key === '0, "R1", "after reset",
              {busy, done, out_key}, '0);

        // Table walk: R5 corner patterns plus R2 and R6 on every vector
        for (int v = 0; v < NV; v++) begin
            run_sort(VECS[v].key, v, VECS[v].exp_key, "R5", 1'b0);
            @(negedge clk);
            check(done === 1'b0, "R2", "done single cycle", done, 1'b0);
        end

        // R3 and R4: start during busy ignored, input changes ignored
        run_sort(16'h1234, 50, 16'hF800, "R4", 1'b1);
        @(negedge clk);

        // R7: outputs hold while idle and inputs move
        hk = out_key;
        hp = out_pay;
        for (int c = 0; c < 5; c++) begin
            in_key = N'(c * 16'h1357);
            in_pay = ~in_pay;
            @(negedge clk);
        end
        check(out_key === hk && out_pay === hp, "R7", "hold while idle", out_key, hk);

        // R8: back-to-back start in the done cycle
        run_sort(16'h00F0, 60, 16'hF000, "R5", 1'b0);
        run_sort(16'hFF0F, 61, 16'hFFF0, "R8", 1'b0);
        @(negedge clk);

        // Random keys, expected from the count of ones
        for (int t = 0; t < 20; t++) begin
            rk = N'($urandom);
            run_sort(rk, 100 + t, {N{1'b1}} << (N - $countones(rk)), "R5", 1'b0);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule